// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the software-visible register front end of an I/O interrupt controller with a configurable number of input pins (24 by default). Software reaches the internal registers through a byte-addressed access port. It first writes an index into a selector register. It then reads or writes the chosen register through a 32-bit data window. The internal registers are an identification register, a read-only version register, a read-only arbitration register, and one 64-bit redirection entry per pin. Each entry is reached as two 32-bit halves.

The block exports every field of every entry to the delivery logic that sits beside it. A one-cycle pulse marks each entry that has just been written, so that this neighbour can re-evaluate the pin. The delivery logic supplies two things in return: per-pin set and clear requests for the remote-IRR status bit, and a per-pin delivery-pending level. Both are shown in the entry's read value. A write to the end-of-interrupt port forwards its low byte as a vector on a one-cycle strobe.

Top module: `irq_regwin`

## Requirements
- R1: After reset every entry reads with only its mask bit (bit 16 of the lower half) set, all other entry bits zero, the selector is 0x00, the ID field is zero, and no update or end-of-interrupt strobe is active.
- R2: An access is taken only when its size is 1 to 8 bytes; other sizes are ignored completely. A taken read gives `rd_valid` and `rd_data` exactly one cycle later. Offsets 0x04 and 0x40 read zero, and so does any offset other than 0x00 and 0x10.
- R3: A taken write to offset 0x00 loads the selector from data bits 7:0, whatever the size. A read of offset 0x00 returns the selector zero-extended. Writes to offset 0x04 have no effect.
- R4: Selector 0x00 is the ID register: a window write stores data bits 27:24 only, and reads return that field in bits 27:24 with every other bit zero. Selector 0x02 reads the same value, and writes to it are ignored.
- R5: Selector 0x01 is read-only and returns ((PINS-1) << 16) | 0x20. For 24 pins that is 0x00170020.
- R6: Selectors 0x03 to 0x0F read zero and ignore writes. Selector s >= 0x10 reaches entry (s-0x10)>>1, with an odd s selecting the upper half. A selector past the last entry reads 0xFFFFFFFF and ignores writes.
- R7: The lower half of an entry holds vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 (1 = level) and mask 16. The upper half holds the destination in bits 31:24 (entry bits 63:56). Reserved bits read zero. Bit 12 reads the pin's `dlv_pending` input.
- R8: A lower-half write never loads bits 12 or 14 from the data. Remote IRR is kept when the written trigger bit is 1 and is cleared when it is 0. A clear caused by such a write wins over `irr_set`, and `irr_set` wins over `irr_clr` in the same cycle.
- R9: Each accepted entry write pulses that pin's `ent_updated` bit for one cycle, the cycle after the write, when the exported fields already carry the new values. At most one bit pulses at a time.
- R10: A data-window write whose size is not exactly 4 bytes is dropped.
- R11: A taken write to offset 0x40 raises `eoi_valid` for one cycle, the cycle after the write, with `eoi_vector` equal to data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after a read |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector carried with eoi_valid |
| irr_set | input | PINS | Per-pin remote-IRR set request |
| irr_clr | input | PINS | Per-pin remote-IRR clear request |
| dlv_pending | input | PINS | Per-pin delivery-pending level |
| ent_vector | output | 8*PINS | Vector of each entry |
| ent_dmode | output | 3*PINS | Delivery mode of each entry |
| ent_destmode | output | PINS | Destination mode of each entry |
| ent_polarity | output | PINS | Polarity of each entry |
| ent_level | output | PINS | Trigger bit of each entry (1 = level) |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_remote_irr | output | PINS | Remote-IRR state of each entry |
| ent_dest | output | 8*PINS | Destination of each entry |
| ent_updated | output | PINS | One-cycle pulse after an entry write |

## Verification
Read data, the end-of-interrupt strobe and the update pulse all appear in the cycle after the access that caused them. New entry fields and remote-IRR changes show on the exports in that same cycle. The bench drives each access on a falling edge and advances its reference model on the next rising edge. The model uses only the bench's own stimulus and state. At the following falling edge the bench compares every output with the model. A result that lands one cycle early or late therefore fails the comparison of that cycle.

// File: rtl/irw_pkg.sv
// Package: shared constants and types for the interrupt register window.
// Assumes byte offsets fit in 8 bits and selectors are 8 bits wide.
package irw_pkg;
    localparam logic [7:0] OFS_SEL   = 8'h00;
    localparam logic [7:0] OFS_PAD   = 8'h04;
    localparam logic [7:0] OFS_WIN   = 8'h10;
    localparam logic [7:0] OFS_EOI   = 8'h40;
    localparam logic [7:0] SEL_ENT0  = 8'h10;
    localparam logic [7:0] VER_CODE  = 8'h20;
    localparam int         TRIG_BIT  = 15;

    typedef enum logic [2:0] {
        K_ID, K_VER, K_ARB, K_RSV, K_ENT, K_NONE
    } sel_kind_e;
endpackage

// File: rtl/irw_decode.sv
// Module: decodes the selector register into a register kind, an entry
// index and a half flag. Assumes PINS is between 2 and 120.
module irw_decode
    import irw_pkg::*;
#(
    parameter int PINS = 24,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic [7:0]      sel,
    output sel_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic            hi
);
    logic [6:0] raw_idx;

    // Map selector value to kind and entry position.
    always_comb begin
        raw_idx = 7'((sel - SEL_ENT0) >> 1);
        hi      = sel[0];
        idx     = IDXW'(raw_idx);
        if (sel == 8'h00)           kind = K_ID;
        else if (sel == 8'h01)      kind = K_VER;
        else if (sel == 8'h02)      kind = K_ARB;
        else if (sel < SEL_ENT0)    kind = K_RSV;
        else if (int'(raw_idx) < PINS) kind = K_ENT;
        else                        kind = K_NONE;
    end
endmodule

// File: rtl/irw_entry.sv
// Module: one redirection entry. Stores the writable fields, tracks the
// remote-IRR bit and pulses 'updated' after any write. Assumes at most one
// of wr_lo / wr_hi is high in a cycle.
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [16:0] lo_wdata,
    input  logic [7:0]  hi_wdata,
    input  logic        irr_set,
    input  logic        irr_clr,
    input  logic        pending,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi,
    output logic [7:0]  vector,
    output logic [2:0]  dmode,
    output logic        destmode,
    output logic        polarity,
    output logic        level,
    output logic        mask,
    output logic        remote_irr,
    output logic [7:0]  dest,
    output logic        updated
);
    logic [7:0] vec_q;
    logic [2:0] dmode_q;
    logic       destm_q, pol_q, lvl_q, mask_q, rirr_q, upd_q;
    logic [7:0] dest_q;
    logic       edge_wr;

    assign edge_wr = wr_lo && !lo_wdata[TRIG_BIT];

    // Configuration fields: mask set at reset, loaded by half writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0; dmode_q <= '0; destm_q <= 1'b0; pol_q <= 1'b0;
            lvl_q <= 1'b0; mask_q <= 1'b1; dest_q <= '0;
        end else if (wr_lo) begin
            vec_q   <= lo_wdata[7:0];
            dmode_q <= lo_wdata[10:8];
            destm_q <= lo_wdata[11];
            pol_q   <= lo_wdata[13];
            lvl_q   <= lo_wdata[15];
            mask_q  <= lo_wdata[16];
        end else if (wr_hi) begin
            dest_q  <= hi_wdata;
        end
    end

    // Remote IRR: edge-mode write clears, then set, then clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)        rirr_q <= 1'b0;
        else if (edge_wr)  rirr_q <= 1'b0;
        else if (irr_set)  rirr_q <= 1'b1;
        else if (irr_clr)  rirr_q <= 1'b0;
    end

    // Update pulse one cycle after either half is written.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wr_lo || wr_hi;
    end

    assign rd_lo = {15'b0, mask_q, lvl_q, rirr_q, pol_q, pending,
                    destm_q, dmode_q, vec_q};
    assign rd_hi = {dest_q, 24'b0};
    assign vector = vec_q;   assign dmode = dmode_q;
    assign destmode = destm_q; assign polarity = pol_q;
    assign level = lvl_q;    assign mask = mask_q;
    assign remote_irr = rirr_q; assign dest = dest_q;
    assign updated = upd_q;

    AST_EDGE_WRITE_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !lo_wdata[TRIG_BIT]) |=> !remote_irr); // R8
    AST_LEVEL_WRITE_KEEPS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && lo_wdata[TRIG_BIT] && !irr_set && !irr_clr) |=> $stable(remote_irr)); // R8
    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> ($stable(vector) && $stable(mask) && $stable(level))); // R7
endmodule

// File: rtl/irq_regwin.sv
// Module: top of the interrupt register window. Decodes byte-offset
// accesses, holds the selector and ID, muxes window reads from the entry
// array and forwards end-of-interrupt writes. Assumes one access per cycle.
module irq_regwin
    import irw_pkg::*;
#(
    parameter int PINS = 24,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [3:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector,
    input  logic [PINS-1:0]   irr_set,
    input  logic [PINS-1:0]   irr_clr,
    input  logic [PINS-1:0]   dlv_pending,
    output logic [8*PINS-1:0] ent_vector,
    output logic [3*PINS-1:0] ent_dmode,
    output logic [PINS-1:0]   ent_destmode,
    output logic [PINS-1:0]   ent_polarity,
    output logic [PINS-1:0]   ent_level,
    output logic [PINS-1:0]   ent_mask,
    output logic [PINS-1:0]   ent_remote_irr,
    output logic [8*PINS-1:0] ent_dest,
    output logic [PINS-1:0]   ent_updated
);
    localparam logic [31:0] VERSION = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

    logic            legal, acc_wr, acc_rd, win_wr, ent_we;
    logic [7:0]      sel_q;
    logic [3:0]      id_q;
    sel_kind_e       kind;
    logic [IDXW-1:0] idx;
    logic            hi;
    logic [31:0]     win_val, rd_next;
    logic [31:0]     lo_w [PINS];
    logic [31:0]     hi_w [PINS];

    assign legal  = (bus_size != 4'd0) && (bus_size <= 4'd8);
    assign acc_wr = bus_valid && legal && bus_write;
    assign acc_rd = bus_valid && legal && !bus_write;
    assign win_wr = acc_wr && (bus_addr == OFS_WIN) && (bus_size == 4'd4);
    assign ent_we = win_wr && (kind == K_ENT);

    irw_decode #(.PINS(PINS)) dec_i (.sel(sel_q), .kind(kind), .idx(idx), .hi(hi));

    // Selector and ID register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (acc_wr && bus_addr == OFS_SEL) sel_q <= bus_wdata[7:0];
            if (win_wr && kind == K_ID)        id_q  <= bus_wdata[27:24];
        end
    end

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_ent
            logic hit;
            assign hit = ent_we && (idx == IDXW'(i));
            irw_entry ent_i (
                .clk(clk), .rst_n(rst_n),
                .wr_lo(hit && !hi), .wr_hi(hit && hi),
                .lo_wdata(bus_wdata[16:0]), .hi_wdata(bus_wdata[31:24]),
                .irr_set(irr_set[i]), .irr_clr(irr_clr[i]),
                .pending(dlv_pending[i]),
                .rd_lo(lo_w[i]), .rd_hi(hi_w[i]),
                .vector(ent_vector[8*i +: 8]), .dmode(ent_dmode[3*i +: 3]),
                .destmode(ent_destmode[i]), .polarity(ent_polarity[i]),
                .level(ent_level[i]), .mask(ent_mask[i]),
                .remote_irr(ent_remote_irr[i]), .dest(ent_dest[8*i +: 8]),
                .updated(ent_updated[i])
            );
        end
    endgenerate

    // Window read value chosen by the decoded selector.
    always_comb begin
        case (kind)
            K_ID, K_ARB: win_val = {4'b0, id_q, 24'b0};
            K_VER:       win_val = VERSION;
            K_ENT:       win_val = hi ? hi_w[idx] : lo_w[idx];
            K_NONE:      win_val = '1;
            default:     win_val = '0;
        endcase
    end

    // Offset-level read mux.
    always_comb begin
        case (bus_addr)
            OFS_SEL: rd_next = {24'b0, sel_q};
            OFS_WIN: rd_next = win_val;
            default: rd_next = '0;
        endcase
    end

    // Registered read return and end-of-interrupt strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            rd_valid  <= acc_rd;
            eoi_valid <= acc_wr && (bus_addr == OFS_EOI);
            if (acc_rd) rd_data <= rd_next;
            if (acc_wr && bus_addr == OFS_EOI) eoi_vector <= bus_wdata[7:0];
        end
    end

    AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write)); // R2
    AST_UPDATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_updated)); // R9
    AST_NARROW_WIN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_WIN && bus_size != 4'd4)
        |=> (ent_updated == '0)); // R10
    AST_EOI_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_EOI && legal)
        |=> (eoi_valid && eoi_vector == $past(bus_wdata[7:0]))); // R11
endmodule

// File: tb/irq_regwin_tb_top.sv
// Bench: behavioural reference model advanced on every rising edge,
// all outputs compared on every falling edge.
module irq_regwin_tb_top;
    localparam int P = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [3:0] bus_size = 4'd4;
    logic [31:0] bus_wdata = '0;
    logic [P-1:0] irr_set = '0, irr_clr = '0, dlv_pending = '0;
    logic [31:0] rd_data; logic rd_valid, eoi_valid; logic [7:0] eoi_vector;
    logic [8*P-1:0] ent_vector, ent_dest; logic [3*P-1:0] ent_dmode;
    logic [P-1:0] ent_destmode, ent_polarity, ent_level, ent_mask, ent_remote_irr, ent_updated;

    always #5 clk = ~clk;

    irq_regwin #(.PINS(P)) dut_i (.*);

    // Reference model state.
    logic [7:0] m_sel; logic [3:0] m_id;
    logic [31:0] m_low [P]; logic [7:0] m_dest [P]; logic m_irr [P];
    logic x_rv, x_eoi; logic [31:0] x_rd; logic [7:0] x_eoiv; logic [P-1:0] x_upd;
    int errors = 0, checks = 0; bit done = 0;

    function automatic logic [31:0] m_win();
        int ix;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'b0, m_id, 24'b0};
        if (m_sel == 8'h01) return ((P - 1) << 16) | 32'h20;
        if (m_sel < 8'h10) return 32'h0;
        ix = (int'(m_sel) - 16) / 2;
        if (ix >= P) return 32'hFFFF_FFFF;
        if (m_sel[0]) return {m_dest[ix], 24'b0};
        return m_low[ix] | (32'(m_irr[ix]) << 14) | (32'(dlv_pending[ix]) << 12);
    endfunction

    task automatic model_edge();
        bit legal, wr, wwin; int ix; bit clr_edge [P];
        x_rv = 0; x_eoi = 0; x_upd = '0;
        if (!rst_n) begin
            m_sel = 0; m_id = 0; x_rd = 0; x_eoiv = 0;
            for (int i = 0; i < P; i++) begin m_low[i] = 32'h1_0000; m_dest[i] = 0; m_irr[i] = 0; end
            return;
        end
        for (int i = 0; i < P; i++) clr_edge[i] = 0;
        legal = bus_valid && bus_size >= 1 && bus_size <= 8;
        wr = legal && bus_write;
        if (legal && !bus_write) begin
            x_rv = 1;
            x_rd = (bus_addr == 8'h00) ? 32'(m_sel) : (bus_addr == 8'h10) ? m_win() : 32'h0;
        end
        wwin = wr && bus_addr == 8'h10 && bus_size == 4;
        if (wwin) begin
            if (m_sel == 0) m_id = bus_wdata[27:24];
            else if (m_sel >= 8'h10) begin
                ix = (int'(m_sel) - 16) / 2;
                if (ix < P) begin
                    x_upd[ix] = 1;
                    if (m_sel[0]) m_dest[ix] = bus_wdata[31:24];
                    else begin
                        m_low[ix] = bus_wdata & 32'h0001_AFFF;
                        clr_edge[ix] = !bus_wdata[15];
                    end
                end
            end
        end
        if (wr && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
        if (wr && bus_addr == 8'h40) begin x_eoi = 1; x_eoiv = bus_wdata[7:0]; end
        for (int i = 0; i < P; i++) begin
            if (clr_edge[i]) m_irr[i] = 0;
            else if (irr_set[i]) m_irr[i] = 1;
            else if (irr_clr[i]) m_irr[i] = 0;
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        bit ok = 1;
        chk({tag, " rd_valid"}, 64'(rd_valid), 64'(x_rv));
        if (x_rv) chk({tag, " rd_data"}, 64'(rd_data), 64'(x_rd));
        chk({tag, " eoi_valid"}, 64'(eoi_valid), 64'(x_eoi));
        if (x_eoi) chk({tag, " eoi_vector"}, 64'(eoi_vector), 64'(x_eoiv));
        chk({tag, " ent_updated"}, 64'(ent_updated), 64'(x_upd));
        for (int i = 0; i < P; i++) begin
            if (ent_vector[8*i +: 8] !== m_low[i][7:0] || ent_dmode[3*i +: 3] !== m_low[i][10:8] ||
                ent_destmode[i] !== m_low[i][11] || ent_polarity[i] !== m_low[i][13] ||
                ent_level[i] !== m_low[i][15] || ent_mask[i] !== m_low[i][16] ||
                ent_remote_irr[i] !== m_irr[i] || ent_dest[8*i +: 8] !== m_dest[i]) ok = 0;
        end
        chk({tag, " exported fields"}, 64'(ok), 64'(1));
    endtask

    task automatic cycle(input string tag);
        @(posedge clk); model_edge();
        @(negedge clk); compare(tag);
    endtask

    task automatic acc(input bit w, input logic [7:0] a, input logic [3:0] s,
                       input logic [31:0] d, input string tag);
        bus_valid = 1; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
        cycle(tag);
        bus_valid = 0; bus_wdata = '0;
    endtask

    task automatic wsel(input logic [7:0] s, input string tag);
        acc(1, 8'h00, 4'd1, {24'hABCDEF, s}, tag);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) cycle("R1");
        rst_n = 1;
        cycle("R1");
        acc(0, 8'h10, 4, 0, "R1");              // ID after reset
        wsel(8'h10, "R3"); acc(0, 8'h10, 4, 0, "R1");
        chk("R1 entry0 lower", 64'(rd_data), 64'h1_0000);
        wsel(8'h3F, "R3"); acc(0, 8'h10, 4, 0, "R1");
        acc(0, 8'h00, 4, 0, "R3");
        chk("R3 selector readback", 64'(rd_data), 64'h3F);
        acc(1, 8'h04, 4, 32'hFFFF_FFFF, "R3"); acc(0, 8'h00, 2, 0, "R3");
        acc(0, 8'h04, 4, 0, "R2"); acc(0, 8'h40, 4, 0, "R2"); acc(0, 8'h20, 4, 0, "R2");
        acc(0, 8'h10, 0, 0, "R2"); acc(0, 8'h10, 9, 0, "R2");
        acc(1, 8'h00, 0, 32'h11, "R2"); acc(0, 8'h00, 8, 0, "R2");
        acc(1, 8'h00, 8, 32'h0000_0000, "R3");
        acc(1, 8'h10, 4, 32'hFFFF_FFFF, "R4"); acc(0, 8'h10, 4, 0, "R4");
        chk("R4 id masked", 64'(rd_data), 64'h0F00_0000);
        wsel(8'h02, "R4"); acc(0, 8'h10, 4, 0, "R4");
        acc(1, 8'h10, 4, 32'h0000_0000, "R4"); acc(0, 8'h10, 4, 0, "R4");
        wsel(8'h01, "R5"); acc(1, 8'h10, 4, 32'h0, "R5"); acc(0, 8'h10, 4, 0, "R5");
        chk("R5 version", 64'(rd_data), 64'h0017_0020);
        wsel(8'h07, "R6"); acc(1, 8'h10, 4, 32'hFFFF_FFFF, "R6"); acc(0, 8'h10, 4, 0, "R6");
        wsel(8'h40, "R6"); acc(0, 8'h10, 4, 0, "R6");
        acc(1, 8'h10, 4, 32'h0, "R6"); wsel(8'hFF, "R6"); acc(0, 8'h10, 4, 0, "R6");
        wsel(8'h1A, "R7"); acc(1, 8'h10, 4, 32'hFFFF_FFFF, "R9"); acc(0, 8'h10, 4, 0, "R7");
        chk("R7 lower half reads back", 64'(rd_data), 64'h0001_AFFF);
        dlv_pending[5] = 1; acc(0, 8'h10, 4, 0, "R7"); dlv_pending[5] = 0;
        wsel(8'h1B, "R7"); acc(1, 8'h10, 4, 32'hA5FF_FFFF, "R9"); acc(0, 8'h10, 4, 0, "R7");
        irr_set[5] = 1; cycle("R8"); irr_set[5] = 0;
        wsel(8'h1A, "R8"); acc(1, 8'h10, 4, 32'h0000_A031, "R8"); acc(0, 8'h10, 4, 0, "R8");
        chk("R8 irr kept on level write", 64'(rd_data[14]), 64'h1);
        wsel(8'h1B, "R8"); acc(1, 8'h10, 4, 32'h0100_0000, "R8");
        wsel(8'h1A, "R8"); acc(1, 8'h10, 4, 32'h0000_0031, "R8"); acc(0, 8'h10, 4, 0, "R8");
        chk("R8 irr cleared on edge write", 64'(rd_data[14]), 64'h0);
        irr_set[5] = 1; acc(1, 8'h10, 4, 32'h0000_0044, "R8"); irr_set[5] = 0;
        irr_set[5] = 1; irr_clr[5] = 1; cycle("R8"); irr_set[5] = 0; cycle("R8");
        irr_clr[5] = 1; cycle("R8"); irr_clr[5] = 0;
        acc(1, 8'h10, 2, 32'h0001_8077, "R10"); acc(1, 8'h10, 8, 32'h0001_8077, "R10");
        acc(0, 8'h10, 4, 0, "R10");
        wsel(8'h3E, "R9"); acc(1, 8'h10, 4, 32'h0000_8123, "R9");
        acc(1, 8'h40, 1, 32'h1234_56C7, "R11"); cycle("R11");
        acc(1, 8'h40, 4, 32'h0000_0009, "R11"); acc(1, 8'h40, 0, 32'h55, "R11");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule